// File: doc/BRIEF.md
# FIFO threshold interrupt controller

This block holds the interrupt and fill-status logic that sits between a transmit byte FIFO, a receive byte FIFO and the CPU that services them. It does not store data. It watches the two fill levels and the push and pop strobes on each side, and it keeps a set of sticky interrupt causes. Each cause is cleared by writing a one to its bit. The block then merges the causes, gated by an enable mask, into one interrupt line.

The transmit side raises a request when the FIFO has drained to its programmed trigger level. The receive side raises a request when the FIFO has filled to its trigger level. A write into a full FIFO is flagged for each direction, and so is a read from an empty one. A trailing timer catches a few received bytes that sit below the receive trigger with no traffic. This lets software collect the tail of a message that would never reach the threshold. A registered snapshot of both levels, each with full and empty flags, is presented for the register decoder.

No data passes through the block, so no port carries a valid/ready handshake. Every strobe is a one-cycle event that the block samples on the rising edge. The block never back-pressures the FIFOs or the CPU. All configuration pins are plain levels.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `int_status`, `irq` and `fifo_status` are all zero.
- R2: When the transmit direction is enabled (control bit 1) and `tx_level` is at or below the transmit trigger (control bits 22:16), status bit 0 is set at the next edge.
- R3: When the receive direction is enabled (control bit 0) and `rx_level` is at or above the receive trigger (control bits 10:4), status bit 1 is set at the next edge.
- R4: With transmit enabled, `tx_wr` while `tx_level` equals DEPTH sets status bit 3, and `tx_rd` while `tx_level` is 0 sets status bit 2.
- R5: With receive enabled, `rx_wr` while `rx_level` equals DEPTH sets status bit 5, and `rx_rd` while `rx_level` is 0 sets status bit 4.
- R6: A disabled direction sets none of its own status bits: bits 0, 2 and 3 for transmit, and bits 1, 4, 5 and 6 for receive.
- R7: A receive cycle is idle when receive is enabled, `rx_level` is between 1 and the receive trigger minus 1, and neither `rx_wr` nor `rx_rd` is high. With L the value of `cfg_trail_cnt`, status bit 6 is set at the edge that ends the (L+1)-th idle cycle in a row. Any cycle that is not idle restarts the count.
- R8: The trailing bit fires once per idle run. If it is cleared while the idle run continues, it stays clear until a push or pop starts a new run.
- R9: When `st_clr_valid` is high, each status bit whose `st_clr_mask` bit is one is cleared at the next edge, and the other bits hold. If a cause of a bit is present in the same cycle, that bit is set anyway.
- R10: `irq` is high in the cycle after an edge exactly when some status bit is set and its `cfg_int_en` bit was one at that edge.
- R11: `fifo_status` is registered and has this layout. The TX level is in bits 6:0, TX full (level equal to DEPTH) is bit 7 and TX empty (level 0) is bit 8. The RX level is in bits 22:16, RX full is bit 23 and RX empty is bit 24. All other bits are zero.
- R12: Status bits are set whether or not their enable bit is one. A status bit with its enable clear leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_ctl | input | 32 | FIFO control word: receive enable, transmit enable and the two trigger fields |
| cfg_int_en | input | 7 | Enable mask, one bit per status bit |
| cfg_trail_cnt | input | TRAIL_W | Trailing idle limit L |
| tx_level | input | clog2(DEPTH+1) | Current transmit FIFO fill |
| rx_level | input | clog2(DEPTH+1) | Current receive FIFO fill |
| tx_wr | input | 1 | CPU write strobe into the transmit FIFO |
| tx_rd | input | 1 | Bus-side pop strobe from the transmit FIFO |
| rx_wr | input | 1 | Bus-side push strobe into the receive FIFO |
| rx_rd | input | 1 | CPU read strobe from the receive FIFO |
| st_clr_valid | input | 1 | Write strobe to the status register |
| st_clr_mask | input | 7 | Write-one-to-clear data for the status register |
| int_status | output | 7 | Sticky interrupt causes |
| fifo_status | output | 32 | Registered fill levels with full and empty flags |
| irq | output | 1 | Merged interrupt request |

## Verification
The assertions assume that each fill level stays between 0 and DEPTH. They also assume that a strobe reports exactly the event of its cycle and is not stretched, because a stretched strobe would count as repeated overruns or as continuous receive activity. The bench drives every input one nanosecond after a rising edge and holds it for a full cycle. It keeps both levels within that range, raises each strobe for a single cycle, and changes the trigger, enable and limit values only between cycles.

// File: rtl/fic_pkg.sv
package fic_pkg;

  localparam int unsigned NSRC   = 7;
  localparam int unsigned TRIG_W = 7;

  // status bit positions
  localparam int unsigned SRC_TX_AE   = 0;
  localparam int unsigned SRC_RX_AF   = 1;
  localparam int unsigned SRC_TX_UR   = 2;
  localparam int unsigned SRC_TX_OR   = 3;
  localparam int unsigned SRC_RX_UR   = 4;
  localparam int unsigned SRC_RX_OR   = 5;
  localparam int unsigned SRC_TRAIL   = 6;

  // control word fields
  localparam int unsigned CTL_RX_EN   = 0;
  localparam int unsigned CTL_TX_EN   = 1;
  localparam int unsigned CTL_RX_TRIG = 4;
  localparam int unsigned CTL_TX_TRIG = 16;

  // direction index used in per-direction arrays
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;
  localparam int unsigned NDIR   = 2;

  typedef struct packed {
    logic              rx_en;
    logic              tx_en;
    logic [TRIG_W-1:0] rx_trig;
    logic [TRIG_W-1:0] tx_trig;
  } fifo_cfg_t;

  function automatic fifo_cfg_t decode_ctl(input logic [31:0] w);
    fifo_cfg_t c;
    c.rx_en   = w[CTL_RX_EN];
    c.tx_en   = w[CTL_TX_EN];
    c.rx_trig = w[CTL_RX_TRIG +: TRIG_W];
    c.tx_trig = w[CTL_TX_TRIG +: TRIG_W];
    return c;
  endfunction

  function automatic logic [31:0] pack_fifo_status(
    input logic [6:0] txl, input logic txf, input logic txe,
    input logic [6:0] rxl, input logic rxf, input logic rxe);
    logic [31:0] w;
    w        = '0;
    w[6:0]   = txl;
    w[7]     = txf;
    w[8]     = txe;
    w[22:16] = rxl;
    w[23]    = rxf;
    w[24]    = rxe;
    return w;
  endfunction

endpackage

// File: rtl/fic_thr_detect.sv
module fic_thr_detect
  import fic_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  fifo_cfg_t        cfg,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             tx_low,
  output logic             rx_high
);

  localparam int unsigned CW = (LVL_W > TRIG_W) ? LVL_W : TRIG_W;

  logic [CW-1:0] tx_l, rx_l, tx_t, rx_t;

  assign tx_l = CW'(tx_level);
  assign rx_l = CW'(rx_level);
  assign tx_t = CW'(cfg.tx_trig);
  assign rx_t = CW'(cfg.rx_trig);

  // drained to the trigger, or filled up to it
  assign tx_low  = cfg.tx_en && (tx_l <= tx_t);
  assign rx_high = cfg.rx_en && (rx_l >= rx_t);

endmodule

// File: rtl/fic_xfer_fault.sv
module fic_xfer_fault #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic             wr,
  input  logic             rd,
  output logic             full,
  output logic             empty,
  output logic             overrun,
  output logic             underrun
);

  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  assign full     = (level == LVL_FULL);
  assign empty    = (level == '0);
  assign overrun  = en && wr && full;
  assign underrun = en && rd && empty;

endmodule

// File: rtl/fic_trail_timer.sv
module fic_trail_timer #(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned TRIG_W  = 7,
  parameter int unsigned TRAIL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LVL_W-1:0]   level,
  input  logic [TRIG_W-1:0]  trig,
  input  logic               activity,
  input  logic [TRAIL_W-1:0] limit,
  output logic               fire
);

  localparam int unsigned CW  = (LVL_W > TRIG_W) ? LVL_W : TRIG_W;
  localparam int unsigned CNW = TRAIL_W + 1;

  logic           armed;
  logic [CNW-1:0] cnt;
  logic [CNW-1:0] lim_x;

  assign lim_x = {1'b0, limit};
  assign armed = en && (level != '0) && (CW'(level) < CW'(trig));

  // counter saturates one past the limit so the event fires once per run
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!armed || activity) begin
      cnt <= '0;
    end else if (cnt <= lim_x) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fire = armed && !activity && (cnt == lim_x);

endmodule

// File: rtl/fic_status_reg.sv
module fic_status_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_valid,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en_mask,
  output logic [N-1:0] status,
  output logic         irq
);

  logic [N-1:0] clr_eff;
  logic [N-1:0] nxt;

  assign clr_eff = clr_valid ? clr_mask : '0;
  // a cause present in the clearing cycle wins over the clear
  assign nxt     = (status & ~clr_eff) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |(nxt & en_mask);
    end
  end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRAIL_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [31:0]                  cfg_fifo_ctl,
  input  logic [NSRC-1:0]              cfg_int_en,
  input  logic [TRAIL_W-1:0]           cfg_trail_cnt,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input  logic                         tx_wr,
  input  logic                         tx_rd,
  input  logic                         rx_wr,
  input  logic                         rx_rd,
  input  logic                         st_clr_valid,
  input  logic [NSRC-1:0]              st_clr_mask,
  output logic [NSRC-1:0]              int_status,
  output logic [31:0]                  fifo_status,
  output logic                         irq
);

  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  fifo_cfg_t cfg;
  logic      ctl_unused;

  assign cfg        = decode_ctl(cfg_fifo_ctl);
  assign ctl_unused = ^cfg_fifo_ctl;

  // per-direction fault detection, index DIR_TX / DIR_RX
  logic [NDIR-1:0]  d_en, d_wr, d_rd;
  logic [NDIR-1:0]  d_full, d_empty, d_ovf, d_udf;
  logic [LVL_W-1:0] d_lvl [NDIR];

  assign d_en[DIR_TX]  = cfg.tx_en;
  assign d_en[DIR_RX]  = cfg.rx_en;
  assign d_wr[DIR_TX]  = tx_wr;
  assign d_wr[DIR_RX]  = rx_wr;
  assign d_rd[DIR_TX]  = tx_rd;
  assign d_rd[DIR_RX]  = rx_rd;
  assign d_lvl[DIR_TX] = tx_level;
  assign d_lvl[DIR_RX] = rx_level;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    fic_xfer_fault #(
      .DEPTH (DEPTH),
      .LVL_W (LVL_W)
    ) u_fault (
      .en       (d_en[d]),
      .level    (d_lvl[d]),
      .wr       (d_wr[d]),
      .rd       (d_rd[d]),
      .full     (d_full[d]),
      .empty    (d_empty[d]),
      .overrun  (d_ovf[d]),
      .underrun (d_udf[d])
    );
  end

  logic tx_low, rx_high, trail_fire;

  fic_thr_detect #(
    .LVL_W (LVL_W)
  ) u_thr (
    .cfg      (cfg),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_low   (tx_low),
    .rx_high  (rx_high)
  );

  fic_trail_timer #(
    .LVL_W   (LVL_W),
    .TRIG_W  (TRIG_W),
    .TRAIL_W (TRAIL_W)
  ) u_trail (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.rx_en),
    .level    (rx_level),
    .trig     (cfg.rx_trig),
    .activity (rx_wr | rx_rd),
    .limit    (cfg_trail_cnt),
    .fire     (trail_fire)
  );

  logic [NSRC-1:0] set_vec;

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_TX_AE] = tx_low;
    set_vec[SRC_RX_AF] = rx_high;
    set_vec[SRC_TX_UR] = d_udf[DIR_TX];
    set_vec[SRC_TX_OR] = d_ovf[DIR_TX];
    set_vec[SRC_RX_UR] = d_udf[DIR_RX];
    set_vec[SRC_RX_OR] = d_ovf[DIR_RX];
    set_vec[SRC_TRAIL] = trail_fire;
  end

  fic_status_reg #(
    .N (NSRC)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_valid (st_clr_valid),
    .clr_mask  (st_clr_mask),
    .en_mask   (cfg_int_en),
    .status    (int_status),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_status <= '0;
    end else begin
      fifo_status <= pack_fifo_status(7'(tx_level), d_full[DIR_TX], d_empty[DIR_TX],
                                      7'(rx_level), d_full[DIR_RX], d_empty[DIR_RX]);
    end
  end

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk
  import fic_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TRAIL_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [31:0]                cfg_fifo_ctl,
  input logic [NSRC-1:0]            cfg_int_en,
  input logic [$clog2(DEPTH+1)-1:0] tx_level,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic                       tx_wr,
  input logic                       tx_rd,
  input logic                       rx_wr,
  input logic                       rx_rd,
  input logic                       st_clr_valid,
  input logic [NSRC-1:0]            st_clr_mask,
  input logic [NSRC-1:0]            int_status,
  input logic [31:0]                fifo_status,
  input logic                       irq
);

  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam int unsigned CW    = (LVL_W > TRIG_W) ? LVL_W : TRIG_W;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  fifo_cfg_t c;
  logic      chk_unused;
  assign c          = decode_ctl(cfg_fifo_ctl);
  assign chk_unused = ^{cfg_fifo_ctl, fifo_status};

  a_r2_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
    (c.tx_en && (CW'(tx_level) <= CW'(c.tx_trig))) |=> int_status[SRC_TX_AE]);

  a_r3_rx_high: assert property (@(posedge clk) disable iff (!rst_n)
    (c.rx_en && (CW'(rx_level) >= CW'(c.rx_trig))) |=> int_status[SRC_RX_AF]);

  a_r4_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (c.tx_en && tx_wr && tx_level == LVL_FULL) |=> int_status[SRC_TX_OR]);

  a_r4_tx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (c.tx_en && tx_rd && tx_level == '0) |=> int_status[SRC_TX_UR]);

  a_r5_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (c.rx_en && rx_wr && rx_level == LVL_FULL) |=> int_status[SRC_RX_OR]);

  a_r5_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (c.rx_en && rx_rd && rx_level == '0) |=> int_status[SRC_RX_UR]);

  a_r6_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.tx_en && !int_status[SRC_TX_AE] && !int_status[SRC_TX_UR] && !int_status[SRC_TX_OR])
    |=> (!int_status[SRC_TX_AE] && !int_status[SRC_TX_UR] && !int_status[SRC_TX_OR]));

  a_r6_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.rx_en && !int_status[SRC_RX_AF] && !int_status[SRC_RX_UR] &&
     !int_status[SRC_RX_OR] && !int_status[SRC_TRAIL])
    |=> (!int_status[SRC_RX_AF] && !int_status[SRC_RX_UR] &&
         !int_status[SRC_RX_OR] && !int_status[SRC_TRAIL]));

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (int_status[i] && !(st_clr_valid && st_clr_mask[i])) |=> int_status[i]);
  end

  a_r10_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(int_status & $past(cfg_int_en))));

  a_r11_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |=> fifo_status[8]);

  a_r11_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LVL_FULL) |=> fifo_status[23]);

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(
  .DEPTH   (DEPTH),
  .TRAIL_W (TRAIL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_fifo_ctl (cfg_fifo_ctl),
  .cfg_int_en   (cfg_int_en),
  .tx_level     (tx_level),
  .rx_level     (rx_level),
  .tx_wr        (tx_wr),
  .tx_rd        (tx_rd),
  .rx_wr        (rx_wr),
  .rx_rd        (rx_rd),
  .st_clr_valid (st_clr_valid),
  .st_clr_mask  (st_clr_mask),
  .int_status   (int_status),
  .fifo_status  (fifo_status),
  .irq          (irq)
);

// File: tb/fifo_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_tb_top;

  localparam int unsigned DEPTH   = 16;
  localparam int unsigned TRAIL_W = 4;
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [31:0]        cfg_fifo_ctl = '0;
  logic [6:0]         cfg_int_en = '0;
  logic [TRAIL_W-1:0] cfg_trail_cnt = '0;
  logic [LVL_W-1:0]   tx_level = '0;
  logic [LVL_W-1:0]   rx_level = '0;
  logic               tx_wr = 1'b0, tx_rd = 1'b0, rx_wr = 1'b0, rx_rd = 1'b0;
  logic               st_clr_valid = 1'b0;
  logic [6:0]         st_clr_mask = '0;
  logic [6:0]         int_status;
  logic [31:0]        fifo_status;
  logic               irq;

  always #2.5 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .TRAIL_W(TRAIL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_ctl(cfg_fifo_ctl), .cfg_int_en(cfg_int_en),
    .cfg_trail_cnt(cfg_trail_cnt), .tx_level(tx_level), .rx_level(rx_level),
    .tx_wr(tx_wr), .tx_rd(tx_rd), .rx_wr(rx_wr), .rx_rd(rx_rd),
    .st_clr_valid(st_clr_valid), .st_clr_mask(st_clr_mask),
    .int_status(int_status), .fifo_status(fifo_status), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // scoreboard queues
  logic [6:0]  q_st  [$];
  logic        q_irq [$];
  logic [31:0] q_fs  [$];
  string       q_tag [$];

  function automatic logic [31:0] mkctl(bit rxe, bit txe, int rt, int tt);
    logic [31:0] w;
    w        = '0;
    w[0]     = rxe;
    w[1]     = txe;
    w[10:4]  = rt[6:0];
    w[22:16] = tt[6:0];
    return w;
  endfunction

  // layout of R11
  function automatic logic [31:0] exp_fs(int t, int r);
    logic [31:0] w;
    w        = '0;
    w[6:0]   = t[6:0];
    w[7]     = (t == DEPTH);
    w[8]     = (t == 0);
    w[22:16] = r[6:0];
    w[23]    = (r == DEPTH);
    w[24]    = (r == 0);
    return w;
  endfunction

  task automatic compare(string tag, logic [6:0] e_st, logic e_irq, logic [31:0] e_fs);
    n_checks++;
    if (int_status !== e_st || irq !== e_irq || fifo_status !== e_fs) begin
      n_fail++;
      $display("FAIL %s: int_status=%h irq=%b fifo_status=%h expected int_status=%h irq=%b fifo_status=%h (R11 for fifo_status)",
               tag, int_status, irq, fifo_status, e_st, e_irq, e_fs);
    end
  endtask

  // driver: one clock with the inputs currently applied, then queue the expectation
  task automatic step(logic [6:0] e_st, logic e_irq, string tag);
    @(posedge clk);
    #1;
    q_st.push_back(e_st);
    q_irq.push_back(e_irq);
    q_fs.push_back(exp_fs(int'(tx_level), int'(rx_level)));
    q_tag.push_back(tag);
    tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0;
    st_clr_valid = 0; st_clr_mask = '0;
  endtask

  task automatic clr(logic [6:0] m);
    st_clr_valid = 1'b1;
    st_clr_mask  = m;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_tag.size() != 0) begin
        compare(q_tag.pop_front(), q_st.pop_front(), q_irq.pop_front(), q_fs.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset state", 7'h00, 1'b0, 32'h0);
    rst_n = 1'b1;
    cfg_trail_cnt = 4'd3;

    // R6: both directions disabled, every cause present
    tx_rd = 1; rx_rd = 1;
    step(7'h00, 0, "R6 disabled directions ignore causes");

    // R2 / R12 / R10
    cfg_fifo_ctl = mkctl(0, 1, 0, 4);
    tx_level = 5;
    step(7'h00, 0, "R2 above trigger");
    tx_level = 4;
    step(7'h01, 0, "R2 at trigger, R12 masked");
    cfg_int_en = 7'h01;
    step(7'h01, 1, "R10 enabled bit drives irq");

    // R9
    clr(7'h01);
    step(7'h01, 1, "R9 set wins over clear");
    tx_level = 10; clr(7'h01);
    step(7'h00, 0, "R9 clear");

    // R4
    tx_level = 16; tx_wr = 1;
    step(7'h08, 0, "R4 tx overrun, R12 not enabled");
    cfg_int_en = 7'h08;
    step(7'h08, 1, "R10 overrun enabled");
    tx_level = 0; tx_rd = 1;
    step(7'h0D, 1, "R4 tx underrun");
    tx_level = 10; clr(7'h7F);
    step(7'h00, 0, "R9 clear all");

    // R3 / R5 with transmit disabled
    cfg_fifo_ctl = mkctl(1, 0, 6, 4);
    rx_level = 5;
    step(7'h00, 0, "R3 below trigger");
    rx_level = 6;
    step(7'h02, 0, "R3 at trigger");
    rx_level = 16; rx_wr = 1;
    step(7'h22, 0, "R5 rx overrun");
    rx_level = 0; rx_rd = 1;
    step(7'h32, 0, "R5 rx underrun");
    rx_level = 3; rx_rd = 1; clr(7'h7F);
    step(7'h00, 0, "R9 clear with activity");

    // R7: limit 3, four idle cycles
    cfg_int_en = 7'h40;
    step(7'h00, 0, "R7 idle 1");
    step(7'h00, 0, "R7 idle 2");
    step(7'h00, 0, "R7 idle 3 not yet");
    step(7'h40, 1, "R7 idle 4 fires");

    // R8: once per run, restart on activity
    clr(7'h40);
    step(7'h00, 0, "R8 cleared stays clear");
    for (int i = 0; i < 3; i++) step(7'h00, 0, "R8 no refire");
    rx_wr = 1;
    step(7'h00, 0, "R8 push restarts");
    step(7'h00, 0, "R8 idle 1");
    step(7'h00, 0, "R8 idle 2");
    step(7'h00, 0, "R8 idle 3");
    step(7'h40, 1, "R8 refires after new run");

    // R7 zero limit
    cfg_trail_cnt = '0; clr(7'h40); rx_rd = 1;
    step(7'h00, 0, "R7 zero limit, activity");
    step(7'h40, 1, "R7 zero limit first idle fires");

    // R6 both disabled again
    cfg_fifo_ctl = mkctl(0, 0, 6, 4); clr(7'h7F);
    step(7'h00, 0, "R6 clear");
    rx_level = 0; rx_rd = 1; tx_level = 16; tx_wr = 1;
    step(7'h00, 0, "R6 no underrun/overrun");
    rx_level = 16; rx_wr = 1; tx_level = 0; tx_rd = 1;
    step(7'h00, 0, "R6 no overrun/underrun/threshold");
    rx_level = 3;
    for (int i = 0; i < 3; i++) step(7'h00, 0, "R6 no trailing");

    while (q_tag.size() != 0) @(negedge clk);
    #1;
    finish_run();
  end

endmodule